// File: doc/BRIEF.md
# SMBus Clock-Low and Bus-Idle Watchdog

This block watches the two wires of an SMBus or I2C style bus and reports two conditions to the surrounding controller. The first is a clock-stuck condition. When SCL has been held low without a break for a programmable number of coarse ticks, the block emits a one-cycle timeout pulse. The default is 25 ticks of a 1 ms-scale prescaled strobe, which is 25 ms. The second is bus release. Once both SCL and SDA have stayed high for more than a programmable number of periods of the SMBus clock-source strobe, the block raises a level that says the bus may be taken.

Both wires are first passed through a two-flop synchronizer, and every count works on the synchronized copies. The low-time counter sits at its reload value (zero) for as long as SCL is high. It advances on the coarse strobe only while SCL is low. Each detector has its own enable. A synchronous soft-reset input clears both counters, so software can recover from a timeout by disabling and then re-enabling the bus logic.

Top module: `smb_timeout_mon`

## Requirements
- R1: `scl_in` and `sda_in` each pass through two flip-flops before any use. A falling edge on a pin takes away an asserted `bus_free` exactly two clock edges after the pin changes, and not one edge after it.
- R2: With `low_to_en`=1 and synchronized SCL low, each `ms_tick` cycle adds one to the low count. The tick that brings the count to `LOW_LIMIT` makes `low_timeout` 1 for exactly the following cycle.
- R3: While synchronized SCL is high, the low count is held at zero. Low periods shorter than `LOW_LIMIT` ticks that are separated by a high period never produce a timeout.
- R4: After a timeout, further ticks with SCL still low produce no new pulse. Once SCL has gone high and low again, a new run of `LOW_LIMIT` ticks produces a new pulse.
- R5: With `low_to_en`=0, the low count is held at zero and `low_timeout` stays 0 whatever the ticks are.
- R6: With `free_en`=1 and both synchronized lines high, each `src_tick` cycle adds one to the idle count. `bus_free` goes to 1 right after the (`FREE_PERIODS`+1)-th such tick and not earlier.
- R7: `bus_free` drops in the same cycle that either synchronized line is low. The idle count restarts from zero, so a full new idle window is needed.
- R8: With `free_en`=0, `bus_free` is 0 and the idle count is held at zero.
- R9: `soft_rst`=1 for one cycle clears both counts. A partial low run must then restart in full before a timeout is issued, and `bus_free` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of both detectors |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| src_tick | input | 1 | One-cycle strobe, one per SMBus clock-source period |
| ms_tick | input | 1 | One-cycle coarse strobe, about 1 ms apart |
| low_to_en | input | 1 | Enable for the SCL-low timeout detector |
| free_en | input | 1 | Enable for the bus-free detector |
| low_timeout | output | 1 | One-cycle pulse when SCL has been low for LOW_LIMIT ticks |
| bus_free | output | 1 | High while the bus has been idle for more than FREE_PERIODS periods |

## Verification
The hardest case to reach from the ports is a low period that falls exactly one tick short of the limit and then continues across a high break. This case shows whether the count really reloads, rather than being merely paused, while SCL is high. The bench sweeps the number of low ticks from zero to past the limit, with the limit shrunk to a few ticks. It then builds two back-to-back runs of one tick short, joined by a short high break, and adds a soft reset placed in the middle of a run. The sweep checks the exact cycle and the uniqueness of every pulse. The idle window is swept in the same way. A line is then dropped while the bus is free, and the exact cycle in which the level falls through the synchronizer is checked.

// File: rtl/smb_timeout_mon.sv
module smb_timeout_mon #(
  parameter int LOW_LIMIT    = 25,
  parameter int FREE_PERIODS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic scl_in,
  input  logic sda_in,
  input  logic src_tick,
  input  logic ms_tick,
  input  logic low_to_en,
  input  logic free_en,
  output logic low_timeout,
  output logic bus_free
);
  localparam int LW = $clog2(LOW_LIMIT + 1);
  localparam int FW = $clog2(FREE_PERIODS + 2);
  localparam logic [LW-1:0] LMAX = LW'(LOW_LIMIT);
  localparam logic [FW-1:0] FMAX = FW'(FREE_PERIODS + 1);

  logic [1:0] scl_q, sda_q;
  logic [LW-1:0] low_cnt;
  logic [FW-1:0] idle_cnt;
  logic hit;

  wire scl_s    = scl_q[1];
  wire sda_s    = sda_q[1];
  wire low_run  = low_to_en & ~scl_s & ~soft_rst;
  wire idle_run = free_en & scl_s & sda_s & ~soft_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
    end else begin
      scl_q <= {scl_q[0], scl_in};
      sda_q <= {sda_q[0], sda_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      low_cnt <= '0;
      hit     <= 1'b0;
    end else begin
      hit <= low_run & ms_tick & (low_cnt == LMAX - LW'(1));
      if (!low_run)
        low_cnt <= '0;
      else if (ms_tick && low_cnt != LMAX)
        low_cnt <= low_cnt + LW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      idle_cnt <= '0;
    else if (!idle_run)
      idle_cnt <= '0;
    else if (src_tick && idle_cnt != FMAX)
      idle_cnt <= idle_cnt + FW'(1);

  assign low_timeout = hit;
  assign bus_free    = free_en & scl_s & sda_s & (idle_cnt == FMAX);
endmodule

// File: rtl/smb_timeout_mon_chk.sv
module smb_timeout_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic low_to_en,
  input logic free_en,
  input logic scl_s,
  input logic sda_s,
  input logic low_timeout,
  input logic bus_free
);
  a_r2_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    low_timeout |=> !low_timeout);
  a_r3_timeout_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    low_timeout |-> !$past(scl_s));
  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !low_to_en |=> !low_timeout);
  a_r6_free_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free |-> ($past(scl_s) && $past(sda_s)));
  a_r8_free_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !free_en |-> !bus_free);
  a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!low_timeout && !bus_free));
endmodule

bind smb_timeout_mon smb_timeout_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .low_to_en(low_to_en),
  .free_en(free_en), .scl_s(scl_q[1]), .sda_s(sda_q[1]),
  .low_timeout(low_timeout), .bus_free(bus_free)
);

// File: tb/test_smb_timeout_mon.sv
module test_smb_timeout_mon;
  localparam int L = 6;
  localparam int F = 4;

  logic clk = 0, rst_n = 0, soft_rst = 0, scl_in = 1, sda_in = 1;
  logic src_tick = 0, ms_tick = 0, low_to_en = 1, free_en = 1;
  logic low_timeout, bus_free;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  smb_timeout_mon #(.LOW_LIMIT(L), .FREE_PERIODS(F)) i_smb_timeout_mon (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .scl_in(scl_in),
    .sda_in(sda_in), .src_tick(src_tick), .ms_tick(ms_tick),
    .low_to_en(low_to_en), .free_en(free_en),
    .low_timeout(low_timeout), .bus_free(bus_free));

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one coarse tick; sample the pulse cycle, then the cycle after it
  task automatic mtick(input logic exp, input string req);
    ms_tick = 1;
    @(negedge clk);
    ms_tick = 0;
    chk(low_timeout, exp, req);
    @(negedge clk);
    chk(low_timeout, 1'b0, req);
  endtask

  task automatic stick(input logic exp, input string req);
    src_tick = 1;
    @(negedge clk);
    src_tick = 0;
    chk(bus_free, exp, req);
  endtask

  task automatic fresh_low;
    scl_in = 1; idle(3);
    scl_in = 0; idle(3);
  endtask

  task automatic fresh_idle;
    sda_in = 0; idle(3);
    sda_in = 1; scl_in = 1; idle(3);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: got hang expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk(low_timeout, 1'b0, "reset");
    chk(bus_free, 1'b0, "reset");

    // R2 / R4: sweep low length
    for (int n = 0; n <= L + 3; n++) begin
      fresh_low();
      for (int i = 1; i <= n; i++) mtick(i == L, "R2_R4 sweep");
    end
    // R4: new pulse after SCL returns high
    fresh_low();
    for (int i = 1; i <= L; i++) mtick(i == L, "R4 rearm");

    // R3: two short runs split by a high break
    fresh_low();
    for (int i = 1; i < L; i++) mtick(1'b0, "R3 first run");
    scl_in = 1; idle(3);
    mtick(1'b0, "R3 tick while high");
    scl_in = 0; idle(3);
    for (int i = 1; i < L; i++) mtick(1'b0, "R3 second run");
    mtick(1'b1, "R3 full after reload");

    // R9: soft reset mid-run
    fresh_low();
    for (int i = 1; i < L; i++) mtick(1'b0, "R9 pre");
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    for (int i = 1; i <= L; i++) mtick(i == L, "R9 restart");

    // R5: detector disabled
    low_to_en = 0;
    fresh_low();
    for (int i = 1; i <= L + 2; i++) mtick(1'b0, "R5 disabled");
    low_to_en = 1;
    for (int i = 1; i <= L; i++) mtick(i == L, "R5 reenabled");

    // R6: sweep idle window
    for (int n = 0; n <= F + 3; n++) begin
      fresh_idle();
      chk(bus_free, 1'b0, "R6 before ticks");
      for (int i = 1; i <= n; i++) stick(i > F, "R6 sweep");
    end

    // R1 / R7: SDA drop through synchronizer, then full restart
    fresh_idle();
    for (int i = 1; i <= F + 1; i++) stick(i > F, "R7 setup");
    sda_in = 0;
    @(negedge clk); chk(bus_free, 1'b1, "R1 one edge");
    @(negedge clk); chk(bus_free, 1'b0, "R1_R7 two edges");
    sda_in = 1; idle(3);
    for (int i = 1; i <= F + 1; i++) stick(i > F, "R7 restart");
    scl_in = 0;
    @(negedge clk); chk(bus_free, 1'b1, "R1 scl one edge");
    @(negedge clk); chk(bus_free, 1'b0, "R7 scl drop");
    scl_in = 1; idle(3);

    // R8: disabled
    for (int i = 1; i <= F + 1; i++) stick(i > F, "R8 setup");
    free_en = 0; @(negedge clk);
    chk(bus_free, 1'b0, "R8 disabled");
    for (int i = 1; i <= F + 3; i++) stick(1'b0, "R8 disabled ticks");
    free_en = 1; idle(1);
    for (int i = 1; i <= F + 1; i++) stick(i > F, "R8 reenabled");

    // R9: soft reset clears idle window
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    chk(bus_free, 1'b0, "R9 free cleared");
    for (int i = 1; i <= F + 1; i++) stick(i > F, "R9 idle restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule